// File: doc/BRIEF.md
# Iterative Multi-Step Shifter

This block runs the three integer shift operations of a 32-bit processor (logical left, logical right and arithmetic right) over several clock cycles. The whole datapath is one register. A four-way selector in front of it picks one of four values each cycle: the incoming operand, the register moved left by one, the register moved left by a larger power-of-two step (eight by default), or the register with its bit order mirrored. A right shift mirrors the operand, steps it left and mirrors it back. For the arithmetic form, each vacated bit takes the operand's original sign.

A controller holds the remaining distance. It takes large steps while at least one large step remains and finishes with single-bit steps. A request is a one-cycle `start` with the operation, operand and distance. The block raises `busy` while it works, ignores further requests until it finishes, and then pulses `done` with the result on `result`. A build-time option makes completion detection simpler at the cost of one more cycle per shift.

Top module: `iter_shifter`

## Requirements
- R1: With `shiftOp` = 2'b00 (or the spare code 2'b11, which acts the same), the result is `operand` shifted left by the distance, with zeros entering at the low end.
- R2: With `shiftOp` = 2'b01, the result is `operand` shifted right by the distance, with zeros entering at the high end.
- R3: With `shiftOp` = 2'b10, the result is `operand` shifted right by the distance, with copies of `operand` bit 31 entering at the high end.
- R4: Only `shiftAmt` bits [4:0] set the distance. Higher bits have no effect on the result or on the timing.
- R5: Call the clock edge that samples an accepted `start` edge 0, and let n be the distance and s = n/8 + n%8. In the default mode, `done` rises at edge s for a left shift and at edge s+2 for a right shift.
- R6: A distance of zero returns the operand unchanged. A zero-distance left shift raises `done` at edge 0, and a zero-distance right shift raises it at edge 2.
- R7: `busy` is high after every edge from edge 0 up to, but not including, the edge that raises `done`. `busy` and `done` are never high together.
- R8: A `start` sampled while `busy` is high is ignored. The running shift keeps its result and timing, and no extra `done` follows.
- R9: `done` is high for a single cycle. `result` keeps its value until another request is accepted.
- R10: With the late-result option, every completion edge of R5 and R6 moves one edge later, and the results are unchanged.
- R11: A `start` in the cycle where `done` is high is accepted, and that new shift completes on its own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when not busy |
| shiftOp | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 left |
| operand | input | DATA_W | Value to shift |
| shiftAmt | input | AMT_W | Distance; only the low log2(DATA_W) bits are used |
| busy | output | 1 | A shift is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Shift result, valid while done is high and held afterwards |

## Verification
Completion and acceptance of the next request can fall in the same cycle: `busy` drops as `done` rises, so a `start` in that cycle is taken at once. The bench provokes this by holding a second request during the `done` cycle of a right shift. It reads the first result in that cycle and then expects the second result after exactly the second request's own latency. The late-result instance gets the same stimulus. It is still busy in that cycle, so it must ignore the request and keep the first result.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_SPARE = 2'b11
  } shOp_e;

  // Source selected in front of the single datapath register.
  typedef enum logic [1:0] {
    SRC_LOAD = 2'b00,
    SRC_ONE  = 2'b01,
    SRC_BIG  = 2'b10,
    SRC_FLIP = 2'b11
  } shSrc_e;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic   en;
    shSrc_e src;
    logic   arith;
  } shStrobe_t;

endpackage

// File: rtl/iter_shift_dp.sv
module iter_shift_dp
  import shf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BIG_STEP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobe_t         strobe,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] value,
  output logic              fillBit
);

  logic [DATA_W-1:0] valueQ;
  logic [DATA_W-1:0] mirrored;
  logic [DATA_W-1:0] stepOne;
  logic [DATA_W-1:0] stepBig;
  logic [DATA_W-1:0] muxOut;
  logic              fillQ;

  // Bit-order mirror, one wire per bit.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign mirrored[i] = valueQ[DATA_W-1-i];
  end

  assign stepOne = {valueQ[DATA_W-2:0], fillQ};

  // Large step; the fill bit enters every vacated low position.
  for (genvar j = 0; j < DATA_W; j++) begin : g_big
    if (j < BIG_STEP) begin : g_fill
      assign stepBig[j] = fillQ;
    end else begin : g_move
      assign stepBig[j] = valueQ[j-BIG_STEP];
    end
  end

  always_comb begin
    unique case (strobe.src)
      SRC_LOAD: muxOut = operand;
      SRC_ONE:  muxOut = stepOne;
      SRC_BIG:  muxOut = stepBig;
      SRC_FLIP: muxOut = mirrored;
      default:  muxOut = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueQ <= '0;
      fillQ  <= 1'b0;
    end else if (strobe.en) begin
      valueQ <= muxOut;
      if (strobe.src == SRC_LOAD) begin
        fillQ <= strobe.arith & operand[DATA_W-1];
      end
    end
  end

  assign value   = valueQ;
  assign fillBit = fillQ;

  // The fill bit changes only when a new operand is loaded.
  assert_fill_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.en && strobe.src == SRC_LOAD) |=> $stable(fillQ));

endmodule

// File: rtl/iter_shift_ctl.sv
module iter_shift_ctl
  import shf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BIG_STEP    = 8,
  parameter int AMT_W       = 8,
  parameter bit LATE_RESULT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opIn,
  input  logic [AMT_W-1:0] amtIn,
  output shStrobe_t        strobe,
  output logic             busy,
  output logic             done
);

  localparam int SW = $clog2(DATA_W);
  localparam logic [SW-1:0] BIG = SW'(BIG_STEP);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLIPIN,
    ST_STEP,
    ST_FLIPOUT,
    ST_FIN
  } state_e;

  state_e        stateQ, stateD;
  logic [SW-1:0] remQ, remD;
  logic          rightQ, rightD;
  logic          doneQ, doneD;
  logic          seenQ;
  shOp_e         opK;
  logic          reqRight;
  logic [SW-1:0] amtLow;

  assign opK      = shOp_e'(opIn);
  assign reqRight = (opK == OP_SRL) || (opK == OP_SRA);
  assign amtLow   = amtIn[SW-1:0];

  always_comb begin
    strobe.en    = 1'b0;
    strobe.src   = SRC_LOAD;
    strobe.arith = (opK == OP_SRA);
    stateD = stateQ;
    remD   = remQ;
    rightD = rightQ;
    doneD  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.en  = 1'b1;
          strobe.src = SRC_LOAD;
          remD       = amtLow;
          rightD     = reqRight;
          if (reqRight) begin
            stateD = ST_FLIPIN;
          end else if (amtLow != '0 || LATE_RESULT) begin
            stateD = ST_STEP;
          end else begin
            doneD = 1'b1;
          end
        end
      end
      ST_FLIPIN: begin
        strobe.en  = 1'b1;
        strobe.src = SRC_FLIP;
        stateD     = ST_STEP;
      end
      ST_STEP: begin
        if (remQ == '0) begin
          // Terminal check on the remaining distance itself.
          if (rightQ) begin
            strobe.en  = 1'b1;
            strobe.src = SRC_FLIP;
          end
          if (LATE_RESULT && rightQ) begin
            stateD = ST_FIN;
          end else begin
            doneD  = 1'b1;
            stateD = ST_IDLE;
          end
        end else begin
          strobe.en = 1'b1;
          if (remQ >= BIG) begin
            strobe.src = SRC_BIG;
            remD       = remQ - BIG;
          end else begin
            strobe.src = SRC_ONE;
            remD       = remQ - 1'b1;
          end
          // Early completion: look ahead at the distance after this step.
          if (!LATE_RESULT && remD == '0) begin
            if (rightQ) begin
              stateD = ST_FLIPOUT;
            end else begin
              doneD  = 1'b1;
              stateD = ST_IDLE;
            end
          end
        end
      end
      ST_FLIPOUT: begin
        strobe.en  = 1'b1;
        strobe.src = SRC_FLIP;
        doneD      = 1'b1;
        stateD     = ST_IDLE;
      end
      ST_FIN: begin
        doneD  = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      remQ   <= '0;
      rightQ <= 1'b0;
      doneQ  <= 1'b0;
      seenQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      remQ   <= remD;
      rightQ <= rightD;
      doneQ  <= doneD;
      seenQ  <= 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  // Every cycle spent stepping strictly reduces the remaining distance.
  assert_rem_shrinks_R5: assert property (@(posedge clk) disable iff (!rstN)
    seenQ && stateQ == ST_STEP && $past(stateQ) == ST_STEP |-> remQ < $past(remQ));

  // The large step is taken whenever it still fits.
  assert_big_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    seenQ && stateQ == ST_STEP && $past(stateQ) == ST_STEP && $past(remQ) >= BIG
    |-> remQ == $past(remQ) - BIG);

  // The captured direction never changes while a shift runs.
  assert_dir_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    seenQ && busy && $past(busy) |-> $stable(rightQ));

  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

endmodule

// File: rtl/iter_shifter.sv
module iter_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BIG_STEP    = 8,
  parameter int AMT_W       = 8,
  parameter bit LATE_RESULT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        shiftOp,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  shiftAmt,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  localparam int SW = $clog2(DATA_W);

  shStrobe_t strobe;
  logic      fillBit;

  iter_shift_ctl #(
    .DATA_W(DATA_W), .BIG_STEP(BIG_STEP), .AMT_W(AMT_W), .LATE_RESULT(LATE_RESULT)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .opIn(shiftOp), .amtIn(shiftAmt),
    .strobe(strobe), .busy(busy), .done(done)
  );

  iter_shift_dp #(
    .DATA_W(DATA_W), .BIG_STEP(BIG_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .operand(operand),
    .value(result), .fillBit(fillBit)
  );

  // Port-level record of the last accepted request, for the checks below.
  logic [1:0] lastOp;
  logic       lastMsb;
  logic       lastNonZero;
  logic       seenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastOp      <= 2'b00;
      lastMsb     <= 1'b0;
      lastNonZero <= 1'b0;
      seenQ       <= 1'b0;
    end else begin
      seenQ <= 1'b1;
      if (start && !busy) begin
        lastOp      <= shiftOp;
        lastMsb     <= operand[DATA_W-1];
        lastNonZero <= (shiftAmt[SW-1:0] != '0);
      end
    end
  end

  assert_srl_zero_top_R2: assert property (@(posedge clk) disable iff (!rstN)
    done && lastOp == 2'b01 && lastNonZero |-> result[DATA_W-1] == 1'b0);

  assert_sra_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    done && lastOp == 2'b10 |-> result[DATA_W-1] == lastMsb && fillBit == lastMsb);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    seenQ && $past(!busy && !start) |-> $stable(result));

endmodule

// File: tb/tb_iter_shifter.sv
module tb_iter_shifter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  shiftOp = 2'b00;
  logic [31:0] operand = '0;
  logic [7:0]  shiftAmt = '0;
  logic        busy, done, busyL, doneL;
  logic [31:0] result, resultL;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  iter_shifter #(.LATE_RESULT(1'b0)) dut (
    .clk(clk), .rstN(rstN), .start(start), .shiftOp(shiftOp), .operand(operand),
    .shiftAmt(shiftAmt), .busy(busy), .done(done), .result(result));

  iter_shifter #(.LATE_RESULT(1'b1)) dutLate (
    .clk(clk), .rstN(rstN), .start(start), .shiftOp(shiftOp), .operand(operand),
    .shiftAmt(shiftAmt), .busy(busyL), .done(doneL), .result(resultL));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] v,
                                        input logic [7:0] amt);
    int n = int'(amt[4:0]);
    case (op)
      2'b01:   return v >> n;
      2'b10:   return $unsigned($signed(v) >>> n);
      default: return v << n;
    endcase
  endfunction

  function automatic int lat(input logic [1:0] op, input logic [7:0] amt, input bit late);
    int n = int'(amt[4:0]);
    int s = n / 8 + n % 8;
    int t = (op == 2'b01 || op == 2'b10) ? s + 2 : s;
    return late ? t + 1 : t;
  endfunction

  // One request on both instances; checks result, latency, busy and quiet after.
  task automatic doShift(input string req, input logic [1:0] op, input logic [31:0] v,
                         input logic [7:0] amt, input bit interfere);
    logic [31:0] exp = model(op, v, amt);
    int tD = lat(op, amt, 1'b0);
    int tL = lat(op, amt, 1'b1);
    int seenD = -1;
    int seenL = -1;
    bit busyBadD = 1'b0;
    bit busyBadL = 1'b0;
    logic [31:0] resD = '0;
    logic [31:0] resL = '0;
    @(negedge clk);
    start = 1'b1; shiftOp = op; operand = v; shiftAmt = amt;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 80; c++) begin
      if (c > 0) @(negedge clk);
      if (seenD < 0) begin
        if (busy !== (c < tD)) busyBadD = 1'b1;
        if (done) begin seenD = c; resD = result; end
      end
      if (seenL < 0) begin
        if (busyL !== (c < tL)) busyBadL = 1'b1;
        if (doneL) begin seenL = c; resL = resultL; end
      end
      if (interfere && c == 1) begin
        start = 1'b1; shiftOp = ~op; operand = ~v; shiftAmt = amt + 8'd3;
      end else if (interfere && c == 2) begin
        start = 1'b0;
      end
      if (seenD >= 0 && seenL >= 0) break;
    end
    start = 1'b0;
    chk(resD == exp, req, "result", resD, exp);
    chk(seenD == tD, (amt[4:0] == 0) ? "R6" : "R5", "done edge", 32'(seenD), 32'(tD));
    chk(!busyBadD, "R7", "busy profile", 32'(busyBadD), 32'h0);
    chk(resL == exp, "R10", "late result", resL, exp);
    chk(seenL == tL, "R10", "late done edge", 32'(seenL), 32'(tL));
    chk(!busyBadL, "R7", "late busy profile", 32'(busyBadL), 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!done && !doneL, interfere ? "R8" : "R9", "no extra done",
          {30'h0, done, doneL}, 32'h0);
      chk(result == exp && resultL == exp, "R9", "result held", result, exp);
    end
  endtask

  // Second request raised in the done cycle of the first (R11).
  task automatic backToBack();
    logic [31:0] expA = 32'h1E1E1E1E;
    logic [31:0] expB = 32'h00000600;
    int seenB = -1;
    int c0 = -1;
    @(negedge clk);
    start = 1'b1; shiftOp = 2'b01; operand = 32'hF0F0F0F0; shiftAmt = 8'd3;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (c > 0) @(negedge clk);
      if (done) begin c0 = c; break; end
    end
    chk(c0 == 5, "R5", "first done edge", 32'(c0), 32'd5);
    chk(result == expA, "R11", "first result in done cycle", result, expA);
    start = 1'b1; shiftOp = 2'b00; operand = 32'h3; shiftAmt = 8'd9;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (c > 0) @(negedge clk);
      if (done) begin seenB = c; break; end
    end
    chk(seenB == 2, "R11", "second done edge", 32'(seenB), 32'd2);
    chk(result == expB, "R11", "second result", result, expB);
    repeat (4) @(negedge clk);
    chk(resultL == expA && !busyL, "R8", "late instance ignored request", resultL, expA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !busyL && !doneL, "R7", "reset flags",
        {28'h0, busy, done, busyL, doneL}, 32'h0);
    chk(result == 0 && resultL == 0, "R9", "reset result", result, 32'h0);

    doShift("R1", 2'b00, 32'h00000001, 8'd5, 1'b0);
    doShift("R1", 2'b00, 32'hDEADBEEF, 8'd13, 1'b0);
    doShift("R1", 2'b00, 32'h80000001, 8'd31, 1'b0);
    doShift("R1", 2'b00, 32'h0000000F, 8'd8, 1'b0);
    doShift("R2", 2'b01, 32'h80000000, 8'd31, 1'b0);
    doShift("R2", 2'b01, 32'hDEADBEEF, 8'd4, 1'b0);
    doShift("R2", 2'b01, 32'h12345678, 8'd16, 1'b0);
    doShift("R3", 2'b10, 32'h80000000, 8'd1, 1'b0);
    doShift("R3", 2'b10, 32'hF0000000, 8'd20, 1'b0);
    doShift("R3", 2'b10, 32'h7FFFFFFF, 8'd9, 1'b0);
    doShift("R3", 2'b10, 32'hFFFFFFFF, 8'd31, 1'b0);
    doShift("R6", 2'b00, 32'hABCD1234, 8'd0, 1'b0);
    doShift("R6", 2'b10, 32'h80000001, 8'd0, 1'b0);
    doShift("R4", 2'b00, 32'h00000001, 8'h25, 1'b0);
    doShift("R4", 2'b01, 32'hCAFEF00D, 8'hE3, 1'b0);
    doShift("R1", 2'b11, 32'h0000ABCD, 8'd12, 1'b0);
    doShift("R8", 2'b01, 32'h89ABCDEF, 8'd20, 1'b1);
    backToBack();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule